// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block carries out the entry phase of a small 8-bit processor's interrupts and its reset. When the core signals an instruction boundary, the sequencer looks at a bitmask of pending requests. Bit 0 is the non-maskable request, bit 1 is a one-shot maskable request, and the remaining bits are level-held maskable sources. It also looks at the interrupt-disable flag as it stood before the current instruction, and at a jammed indicator. From these it decides between non-maskable entry, maskable entry and no entry.

For an entry it writes three bytes to the stack through a synchronous memory port. It then reads a two-byte vector and returns the new program counter, status byte and stack pointer, together with the number of processor cycles to charge. A reset request runs a shorter sequence: it reads the reset vector and reloads the status byte, with no stack writes.

The memory returns read data on the cycle after a read is issued. The core applies the results when `done` pulses. Instruction execution and memory contents belong to other blocks.

Top module: `irq_entry_seq`

## Requirements
- R1: Decisions are made only while idle (`busy` low). A reset request (`rst_req`) wins over everything and is honoured whether or not `boundary` is high. Otherwise, at a `boundary` cycle, pending bit 0 (non-maskable) is served before any maskable bit. `kind` reads 1 for non-maskable, 2 for maskable and 3 for reset while `busy` is high.
- R2: A maskable entry (any of pend bits 1 and up set, bit 0 clear) is started only when `i_prev` is 0. With `i_prev` at 1, no sequence starts.
- R3: While `jammed` is 1, neither kind of interrupt entry starts. A reset request is still honoured.
- R4: An entry writes, on the first three cycles after the deciding cycle, the PC high byte, then the PC low byte, then the status byte with bit 4 forced to 0 and bit 5 forced to 1.
- R5: Each stack write goes to address 0x0100 + S, and S then decrements with 8-bit wraparound. `s_out` is S-3 modulo 256 after an entry, and S unchanged after a reset.
- R6: Vectors are read low byte first, one byte per cycle, on cycles 4 and 5 after the decision. The addresses are 0xFFFA/0xFFFB for non-maskable, 0xFFFE/0xFFFF for maskable and 0xFFFC/0xFFFD for reset (on cycles 1 and 2). `p_out` is the sampled status for non-maskable entry, the sampled status with bit 2 set for maskable entry, and exactly 0x04 after reset.
- R7: `done` is a single-cycle pulse. It arrives 7 cycles after an entry decision or 4 cycles after a reset decision. In that cycle `pc_out` holds the vector, and `cyc_out` reads 7 for an entry and 0 for a reset.
- R8: A reset sequence raises `jam_clr` only in its `done` cycle.
- R9: In the `done` cycle of an interrupt entry, `pend_clr` has exactly bits 0 and 1 set. It is zero at all other times and after a reset.
- R10: The inputs are sampled only in the deciding cycle. Changes to the pending mask, PC, status or stack pointer while `busy` is high have no effect on the running sequence, and they start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | High in the cycle the core finishes an instruction |
| rst_req | input | 1 | Processor reset request |
| pend | input | PEND_W | Pending requests: bit 0 non-maskable, bit 1 one-shot, rest level-held |
| i_prev | input | 1 | Interrupt-disable flag as sampled before the current instruction |
| jammed | input | 1 | Core is jammed |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte |
| s_in | input | 8 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Results valid this cycle |
| kind | output | 2 | Sequence type: 1 non-maskable, 2 maskable, 3 reset |
| pc_out | output | 16 | New program counter |
| p_out | output | 8 | New status byte |
| s_out | output | 8 | New stack pointer |
| cyc_out | output | CYC_W | Cycles to charge |
| pend_clr | output | PEND_W | Pending bits to clear automatically |
| jam_clr | output | 1 | Clear the jammed state |

## Verification
Arbitration is where functions meet in one cycle. The bench drives a non-maskable and a maskable request at the same boundary, a reset request together with a pending non-maskable request, and a non-maskable request while the core is jammed. A behavioural model picks the winner from the requirement order and predicts every memory access and result cycle by cycle, and each port is compared against it on every clock. A further run changes the sampled inputs in the middle of a sequence and expects the stack bytes and results to keep the values taken at the decision.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int PEND_W    = 4,
  parameter int ENTRY_CYC = 7,
  parameter int CYC_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              rst_req,
  input  logic [PEND_W-1:0] pend,
  input  logic              i_prev,
  input  logic              jammed,
  input  logic [15:0]       pc_in,
  input  logic [7:0]        p_in,
  input  logic [7:0]        s_in,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        kind,
  output logic [15:0]       pc_out,
  output logic [7:0]        p_out,
  output logic [7:0]        s_out,
  output logic [CYC_W-1:0]  cyc_out,
  output logic [PEND_W-1:0] pend_clr,
  output logic              jam_clr
);
  localparam logic [PEND_W-1:0] AUTO_CLR = PEND_W'(3);
  localparam logic [PEND_W-1:0] MASKABLE = ~PEND_W'(1);
  localparam logic [1:0] K_NONE = 2'd0, K_NMI = 2'd1, K_IRQ = 2'd2, K_RST = 2'd3;
  localparam logic [7:0] FLAG_I = 8'h04, FLAG_B = 8'h10, FLAG_U = 8'h20;

  typedef enum logic [2:0] {
    S_IDLE, S_PH, S_PL, S_PP, S_VL, S_VH, S_FIN, S_DONE
  } st_t;

  st_t        st;
  logic [1:0] kind_q;
  logic [15:0] pc_q;
  logic [7:0] p_q, s_q;
  logic [15:0] vec_base;

  wire gate   = boundary && !rst_req && !jammed;
  wire go_nmi = gate && pend[0];
  wire go_irq = gate && !pend[0] && |(pend & MASKABLE) && !i_prev;
  wire pushing = (st == S_PH) || (st == S_PL) || (st == S_PP);

  always_comb begin
    case (kind_q)
      K_NMI:   vec_base = 16'hFFFA;
      K_IRQ:   vec_base = 16'hFFFE;
      default: vec_base = 16'hFFFC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= K_NONE;
      pc_q   <= '0;
      p_q    <= '0;
      s_q    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (rst_req || go_nmi || go_irq) begin
            pc_q <= pc_in;
            p_q  <= p_in;
            s_q  <= s_in;
          end
          if (rst_req) begin
            kind_q <= K_RST;
            st     <= S_VL;
          end else if (go_nmi) begin
            kind_q <= K_NMI;
            st     <= S_PH;
          end else if (go_irq) begin
            kind_q <= K_IRQ;
            st     <= S_PH;
          end
        end
        S_PH: begin s_q <= s_q - 8'd1; st <= S_PL; end
        S_PL: begin s_q <= s_q - 8'd1; st <= S_PP; end
        S_PP: begin s_q <= s_q - 8'd1; st <= S_VL; end
        S_VL: st <= S_VH;
        S_VH: begin pc_q[7:0] <= mem_rdata; st <= S_FIN; end
        S_FIN: begin
          pc_q[15:8] <= mem_rdata;
          if (kind_q == K_RST)      p_q <= FLAG_I;
          else if (kind_q == K_IRQ) p_q <= p_q | FLAG_I;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_we    = pushing;
  assign mem_re    = (st == S_VL) || (st == S_VH);
  assign mem_addr  = pushing ? {8'h01, s_q} :
                     mem_re  ? (vec_base | {15'd0, st == S_VH}) : 16'h0000;
  assign mem_wdata = (st == S_PH) ? pc_q[15:8] :
                     (st == S_PL) ? pc_q[7:0]  : ((p_q & ~FLAG_B) | FLAG_U);

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign kind     = kind_q;
  assign pc_out   = pc_q;
  assign p_out    = p_q;
  assign s_out    = s_q;
  assign cyc_out  = (kind_q == K_RST) ? '0 : CYC_W'(ENTRY_CYC);
  assign pend_clr = (done && kind_q != K_RST) ? AUTO_CLR : '0;
  assign jam_clr  = done && (kind_q == K_RST);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic              rst_req,
  input logic [PEND_W-1:0] pend,
  input logic              i_prev,
  input logic              jammed,
  input logic              busy,
  input logic              done,
  input logic [1:0]        kind,
  input logic              mem_we,
  input logic              mem_re,
  input logic [15:0]       mem_addr,
  input logic [PEND_W-1:0] pend_clr
);
  a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rst_req) |=> (busy && kind == 2'd3));

  a_r1_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && boundary && !rst_req && !jammed && pend[0]) |=> (busy && kind == 2'd1));

  a_r2_masked_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rst_req && !pend[0] && i_prev) |=> !busy);

  a_r3_jam_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rst_req && jammed) |=> !busy);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r5_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == 8'h01));

  a_r5_stack_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1));

  a_r6_vector_area: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr[15:3] == 13'h1FFF));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr != '0) |-> (done && pend_clr[1:0] == 2'b11 && (pend_clr >> 2) == '0));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .rst_req(rst_req),
  .pend(pend), .i_prev(i_prev), .jammed(jammed), .busy(busy), .done(done),
  .kind(kind), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .pend_clr(pend_clr)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int PW = 4;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, boundary = 0, rst_req = 0, i_prev = 0, jammed = 0;
  logic [PW-1:0] pend = '0;
  logic [15:0] pc_in = '0;
  logic [7:0] p_in = '0, s_in = '0, mem_rdata = '0;
  logic [15:0] mem_addr, pc_out;
  logic mem_we, mem_re, busy, done, jam_clr;
  logic [7:0] mem_wdata, p_out, s_out;
  logic [1:0] kind;
  logic [CW-1:0] cyc_out;
  logic [PW-1:0] pend_clr;

  always #10 clk = ~clk;

  irq_entry_seq #(.PEND_W(PW), .CYC_W(CW)) u0 (.*);

  always @(posedge clk)
    if (mem_re)
      case (mem_addr)
        16'hFFFA: mem_rdata <= 8'h34;
        16'hFFFB: mem_rdata <= 8'h12;
        16'hFFFC: mem_rdata <= 8'h00;
        16'hFFFD: mem_rdata <= 8'hC0;
        16'hFFFE: mem_rdata <= 8'hCD;
        16'hFFFF: mem_rdata <= 8'hAB;
        default:  mem_rdata <= 8'hEE;
      endcase

  typedef struct packed {
    logic busy, we, re, done, jclr;
    logic [1:0] kind;
    logic [15:0] addr, pc;
    logic [7:0] wdata, p, s;
    logic [CW-1:0] cyc;
    logic [PW-1:0] clr;
  } rec_t;

  rec_t q[$];
  int nchk = 0, nfail = 0, ncyc = 0, mk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input int k);
    rec_t r;
    logic [7:0] s = s_in;
    logic [15:0] v = (k == 1) ? 16'h1234 : (k == 2) ? 16'hABCD : 16'hC000;
    logic [15:0] va = (k == 1) ? 16'hFFFA : (k == 2) ? 16'hFFFE : 16'hFFFC;
    r = '0; r.busy = 1; r.kind = 2'(k);
    if (k != 3) begin
      for (int i = 0; i < 3; i++) begin
        r.we = 1; r.addr = {8'h01, s};
        r.wdata = (i == 0) ? pc_in[15:8] : (i == 1) ? pc_in[7:0] : ((p_in & 8'hEF) | 8'h20);
        q.push_back(r);
        s = s - 8'd1;
      end
      r.we = 0;
    end
    r.re = 1; r.addr = va;     q.push_back(r);
    r.addr = va + 16'd1;       q.push_back(r);
    r.re = 0;                  q.push_back(r);
    r.done = 1; r.pc = v; r.s = s;
    r.p = (k == 3) ? 8'h04 : (k == 2) ? (p_in | 8'h04) : p_in;
    r.cyc = (k == 3) ? '0 : CW'(7);
    r.clr = (k == 3) ? '0 : PW'(3);
    r.jclr = (k == 3);
    q.push_back(r);
    q.push_back('0);
  endtask

  // Reference decision per R1, R2, R3; inputs only looked at when idle (R10)
  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (q.size() == 0) begin
      mk = 0;
      if (rst_req) mk = 3;
      else if (boundary && !jammed) begin
        if (pend[0]) mk = 1;
        else if (pend[PW-1:1] != 0 && !i_prev) mk = 2;
      end
      if (mk != 0) build(mk);
    end
  end

  always @(negedge clk) begin
    rec_t r;
    if (!rst_n) begin
      check("R7 reset busy", busy, 0);
      check("R7 reset done", done, 0);
      check("R5 reset we", mem_we, 0);
    end else begin
      r = (q.size() != 0) ? q.pop_front() : rec_t'('0);
      check("R1 busy", busy, r.busy);
      if (r.busy) check("R1 kind", kind, r.kind);
      check("R5 we", mem_we, r.we);
      check("R6 re", mem_re, r.re);
      if (r.we || r.re) check("R5/R6 addr", mem_addr, r.addr);
      if (r.we) check("R4 wdata", mem_wdata, r.wdata);
      check("R7 done", done, r.done);
      check("R9 pend_clr", pend_clr, r.clr);
      check("R8 jam_clr", jam_clr, r.jclr);
      if (r.done) begin
        check("R7 pc_out", pc_out, r.pc);
        check("R6 p_out", p_out, r.p);
        check("R5 s_out", s_out, r.s);
        check("R7 cyc_out", cyc_out, r.cyc);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 20000) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic step(input logic b, input logic rr, input logic [PW-1:0] pe, input logic ip,
                      input logic jm, input logic [15:0] pc, input logic [7:0] p, input logic [7:0] s);
    @(negedge clk);
    boundary = b; rst_req = rr; pend = pe; i_prev = ip; jammed = jm;
    pc_in = pc; p_in = p; s_in = s;
    @(negedge clk);
    boundary = 0; rst_req = 0;
  endtask

  task automatic settle();
    repeat (9) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8, R3: reset honoured while jammed
    step(0, 1, 4'b0001, 0, 1, 16'h5555, 8'hFF, 8'h80); settle();
    // R2: maskable taken with I clear, level-held source
    step(1, 0, 4'b0100, 0, 0, 16'h8123, 8'h81, 8'hFD); settle();
    // R2: masked by previous I flag
    step(1, 0, 4'b0100, 1, 0, 16'h8200, 8'h04, 8'hFD);
    check("R2 masked stays idle", busy, 0);
    settle();
    // R1: NMI and maskable together
    step(1, 0, 4'b1101, 0, 0, 16'h9000, 8'h40, 8'hF0); settle();
    // R1: NMI ignores the I flag
    step(1, 0, 4'b0001, 1, 0, 16'h9100, 8'h04, 8'hF0); settle();
    // R3: jammed blocks NMI
    step(1, 0, 4'b0011, 0, 1, 16'h9200, 8'h00, 8'hF0);
    check("R3 jammed stays idle", busy, 0);
    settle();
    // R5: stack wrap
    step(1, 0, 4'b0010, 0, 0, 16'hA0B0, 8'h01, 8'h01); settle();
    // R4: B set and U clear in the sampled status
    step(1, 0, 4'b1000, 0, 0, 16'h0102, 8'hDF, 8'h40); settle();
    // R1: reset beats NMI in the same cycle
    step(1, 1, 4'b0001, 0, 0, 16'h7777, 8'hAA, 8'h33); settle();
    // R2: boundary with nothing pending
    step(1, 0, 4'b0000, 0, 0, 16'h1111, 8'h00, 8'h10);
    check("R2 nothing pending idle", busy, 0);
    settle();
    // R10: inputs changed mid-sequence
    step(1, 0, 4'b0001, 0, 0, 16'hBEEF, 8'h02, 8'h22);
    pc_in = 16'h0000; p_in = 8'hFF; s_in = 8'h00; pend = 4'b1111; i_prev = 1;
    settle();
    check("R10 no restart without boundary", busy, 0);
    check("R10 result kept", s_out, 8'h1F);
    // R1: boundary held over two sequences
    step(1, 0, 4'b0001, 0, 0, 16'h4444, 8'h00, 8'hC0);
    boundary = 1;
    repeat (6) @(negedge clk);
    boundary = 0;
    settle(); settle();
    summary();
  end
endmodule